// File: doc/BRIEF.md
# Ping-Pong DMA Channel Controller

This block is one DMA channel that moves bytes to or from memory using two buffers that software programs and the hardware uses in turn. Each buffer has a live address register and a live 13-bit byte counter. A single control word holds the two start bits, the two done flags, a fault flag, the interrupt enable and a pointer that names the buffer in use. Software arms a buffer by writing its start bit. The channel then issues one byte-address request per byte on a request/acknowledge memory port. It advances the address, counts down, and raises the done flag when the count runs out. The pointer then flips to the other buffer, so that software can refill one buffer while the other one runs.

Software reaches the registers through a plain write strobe and a registered read port. The channel never skips a buffer. It always serves the buffer named by the pointer. An address that falls inside a configurable reserved window stops the channel with a fault. The interrupt line goes high when interrupts are enabled and any done or fault flag is set.

Top module: `pingpong_dma_ch`

## Requirements
- R1: After the synchronous reset, every register index reads 0, and `irq` and `mem_req` are low.
- R2: The register map is as follows. Index 0 is the control word. Index 1 is the buffer A address, index 2 the buffer A count, index 3 the buffer B address and index 4 the buffer B count. In the control word, bit 0 is start A, bit 1 is start B, bit 4 is done A, bit 5 is done B, bit 6 is fault, bit 8 is interrupt enable (read/write) and bit 9 is the buffer-in-use pointer. Writing 1 to a start bit sets it, and writing 0 leaves it unchanged. When a buffer's done flag is set, its start bit clears at the same edge.
- R3: The done and fault flags clear when 1 is written to their bit position. Writing 0 to them has no effect.
- R4: The pointer is 0 while buffer A is in use and 1 while buffer B is in use. It toggles at every completion. Only reset clears it, and control writes do not change it.
- R5: When both start bits are set, the buffer named by the pointer is served first and the other one follows. If only the other buffer is armed, no request is issued.
- R6: The address and count registers of a buffer ignore writes while that buffer's start bit is 1.
- R7: A count register keeps only bits 12:0 of a write. Bits 31:13 read as zero.
- R8: If the next byte address lies in the reserved window [RSV_LO, RSV_HI], the fault flag is set and no request is issued for that byte. The start bit stays set and no done flag is raised. While the fault flag is set, the channel stays halted. Once the fault flag is cleared, the check runs again.
- R9: Each transferred byte adds 1 to the address register and subtracts 1 from the count register. Arming a buffer whose count is 0 completes it without any memory request.
- R10: `mem_req` stays high with `mem_addr` unchanged until `mem_ack`. Byte addresses are issued in ascending order from the programmed address.
- R11: `irq` is the registered value of interrupt enable AND (done A OR done B OR fault), one cycle behind the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register index for read and write |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data for the index of the previous cycle |
| mem_req | output | 1 | Byte transfer request |
| mem_addr | output | AW | Byte address of the pending request |
| mem_ack | input | 1 | Memory accepts the pending request at this edge |
| irq | output | 1 | Channel interrupt |

## Verification
The bench presents the memory acknowledge at the falling edge. In that same step it compares `mem_addr` against the next address queued by the driver, because the handshake completes at the following rising edge. Register reads return data at the rising edge after the index is driven, and the bench samples one time unit later. Status flags, start bits and the pointer change at the edge that takes the last acknowledge, or the edge after a zero-count arm. The bench therefore polls the control word until the expected flag appears, and only then compares the whole word. `irq` trails the flags by one further edge, so the bench waits two falling edges after a flag-clearing write before it checks the line.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  localparam int REG_CTRL   = 0;
  localparam int REG_BASE_A = 1;
  localparam int REG_CNT_A  = 2;
  localparam int REG_BASE_B = 3;
  localparam int REG_CNT_B  = 4;

  localparam int BIT_GO_A  = 0;
  localparam int BIT_GO_B  = 1;
  localparam int BIT_FIN_A = 4;
  localparam int BIT_FIN_B = 5;
  localparam int BIT_FAULT = 6;
  localparam int BIT_IE    = 8;
  localparam int BIT_SEL   = 9;

  typedef enum logic {ENG_IDLE = 1'b0, ENG_MOVE = 1'b1} eng_state_e;
endpackage

// File: rtl/pp_buf_regs.sv
module pp_buf_regs #(
  parameter int AW = 32,
  parameter int CW = 13,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_base,
  input  logic          wr_cnt,
  input  logic [DW-1:0] wdata,
  input  logic          armed,
  input  logic          step,
  output logic [AW-1:0] base_q,
  output logic [CW-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (step) begin
      base_q <= base_q + 1'b1;
      cnt_q  <= cnt_q - 1'b1;
    end else if (!armed) begin
      if (wr_base) base_q <= wdata[AW-1:0];
      if (wr_cnt)  cnt_q  <= wdata[CW-1:0];
    end
  end

  // R6
  hold_when_armed_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !step) |=> ($stable(base_q) && $stable(cnt_q)));

  // R9
  step_count_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> (cnt_q == $past(cnt_q) - 1'b1) && (base_q == $past(base_q) + 1'b1));

  // R9
  step_armed_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> armed);
endmodule

// File: rtl/pp_dma_seq.sv
module pp_dma_seq
  import pp_dma_pkg::*;
#(
  parameter int            AW     = 32,
  parameter int            CW     = 13,
  parameter logic [AW-1:0] RSV_LO = 32'hE000_0000,
  parameter logic [AW-1:0] RSV_HI = 32'hEFFF_FFFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    go,
  input  logic          fault,
  input  logic          sel,
  input  logic [AW-1:0] cur_addr,
  input  logic [CW-1:0] cur_cnt,
  input  logic          mem_ack,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          step_o,
  output logic          done_o,
  output logic          fault_o
);
  eng_state_e  state_q, state_d;
  logic [AW-1:0] next_addr;
  logic        rsv_now, rsv_next, live;

  assign next_addr = cur_addr + 1'b1;
  assign rsv_now   = (cur_addr >= RSV_LO) && (cur_addr <= RSV_HI);
  assign rsv_next  = (next_addr >= RSV_LO) && (next_addr <= RSV_HI);
  assign live      = go[sel] && !fault;

  always_comb begin
    state_d = state_q;
    step_o  = 1'b0;
    done_o  = 1'b0;
    fault_o = 1'b0;
    case (state_q)
      ENG_IDLE: begin
        if (live) begin
          if (cur_cnt == '0)  done_o  = 1'b1;
          else if (rsv_now)   fault_o = 1'b1;
          else                state_d = ENG_MOVE;
        end
      end
      ENG_MOVE: begin
        if (mem_ack) begin
          step_o = 1'b1;
          if (cur_cnt == CW'(1)) begin
            done_o  = 1'b1;
            state_d = ENG_IDLE;
          end else if (rsv_next) begin
            fault_o = 1'b1;
            state_d = ENG_IDLE;
          end
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ENG_IDLE;
    else     state_q <= state_d;
  end

  assign mem_req  = (state_q == ENG_MOVE);
  assign mem_addr = cur_addr;

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R5
  req_for_armed_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (go[sel] && !fault));

  // R8
  fault_halts_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |=> !mem_req);
endmodule

// File: rtl/pp_dma_csr.sv
module pp_dma_csr
  import pp_dma_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_we,
  input  logic [DW-1:0] wdata,
  input  logic          done_i,
  input  logic          fault_i,
  output logic [1:0]    go_q,
  output logic [1:0]    fin_q,
  output logic          fault_q,
  output logic          ie_q,
  output logic          sel_q,
  output logic          irq_q
);
  logic [1:0] go_d, fin_d, go_set, fin_clr;
  logic       fault_d, ie_d, sel_d;

  always_comb begin
    go_set  = ctrl_we ? {wdata[BIT_GO_B], wdata[BIT_GO_A]} : 2'b00;
    fin_clr = ctrl_we ? {wdata[BIT_FIN_B], wdata[BIT_FIN_A]} : 2'b00;
    go_d    = go_q | go_set;
    fin_d   = fin_q & ~fin_clr;
    sel_d   = sel_q;
    fault_d = (fault_q & ~(ctrl_we & wdata[BIT_FAULT])) | fault_i;
    ie_d    = ctrl_we ? wdata[BIT_IE] : ie_q;
    if (done_i) begin
      go_d[sel_q]  = 1'b0;
      fin_d[sel_q] = 1'b1;
      sel_d        = ~sel_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      go_q    <= '0;
      fin_q   <= '0;
      fault_q <= 1'b0;
      ie_q    <= 1'b0;
      sel_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      go_q    <= go_d;
      fin_q   <= fin_d;
      fault_q <= fault_d;
      ie_q    <= ie_d;
      sel_q   <= sel_d;
      irq_q   <= ie_q & ((|fin_q) | fault_q);
    end
  end

  // R2
  fin_a_clears_go_chk: assert property (@(posedge clk) disable iff (rst)
    (done_i && !sel_q) |=> (fin_q[0] && !go_q[0]));

  // R2
  fin_b_clears_go_chk: assert property (@(posedge clk) disable iff (rst)
    (done_i && sel_q) |=> (fin_q[1] && !go_q[1]));

  // R4
  sel_only_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    !done_i |=> $stable(sel_q));

  // R11
  irq_off_chk: assert property (@(posedge clk) disable iff (rst)
    !ie_q |=> !irq_q);

  // R11
  irq_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (ie_q && fault_q) |=> irq_q);
endmodule

// File: rtl/pingpong_dma_ch.sv
module pingpong_dma_ch
  import pp_dma_pkg::*;
#(
  parameter int            AW     = 32,
  parameter int            DW     = 32,
  parameter int            CW     = 13,
  parameter int            RA_W   = 3,
  parameter logic [AW-1:0] RSV_LO = 32'hE000_0000,
  parameter logic [AW-1:0] RSV_HI = 32'hEFFF_FFFF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_ack,
  output logic            irq
);
  logic [AW-1:0] base_w [2];
  logic [CW-1:0] cnt_w  [2];
  logic [1:0]    go, fin;
  logic          fault, ie, sel, irq_w;
  logic          step, done, fault_hit, ctrl_we;
  logic [DW-1:0] ctrl_word, rd_d;

  assign ctrl_we = reg_we && (reg_addr == RA_W'(REG_CTRL));

  for (genvar b = 0; b < 2; b++) begin : g_buf
    localparam int BASE_IDX = (b == 0) ? REG_BASE_A : REG_BASE_B;
    localparam int CNT_IDX  = (b == 0) ? REG_CNT_A  : REG_CNT_B;
    pp_buf_regs #(.AW(AW), .CW(CW), .DW(DW)) i_buf (
      .clk    (clk),
      .rst    (rst),
      .wr_base(reg_we && (reg_addr == RA_W'(BASE_IDX))),
      .wr_cnt (reg_we && (reg_addr == RA_W'(CNT_IDX))),
      .wdata  (reg_wdata),
      .armed  (go[b]),
      .step   (step && (sel == 1'(b))),
      .base_q (base_w[b]),
      .cnt_q  (cnt_w[b])
    );
  end

  pp_dma_seq #(.AW(AW), .CW(CW), .RSV_LO(RSV_LO), .RSV_HI(RSV_HI)) i_seq (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .fault   (fault),
    .sel     (sel),
    .cur_addr(sel ? base_w[1] : base_w[0]),
    .cur_cnt (sel ? cnt_w[1] : cnt_w[0]),
    .mem_ack (mem_ack),
    .mem_req (mem_req),
    .mem_addr(mem_addr),
    .step_o  (step),
    .done_o  (done),
    .fault_o (fault_hit)
  );

  pp_dma_csr #(.DW(DW)) i_csr (
    .clk    (clk),
    .rst    (rst),
    .ctrl_we(ctrl_we),
    .wdata  (reg_wdata),
    .done_i (done),
    .fault_i(fault_hit),
    .go_q   (go),
    .fin_q  (fin),
    .fault_q(fault),
    .ie_q   (ie),
    .sel_q  (sel),
    .irq_q  (irq_w)
  );

  assign irq = irq_w;

  always_comb begin
    ctrl_word            = '0;
    ctrl_word[BIT_GO_A]  = go[0];
    ctrl_word[BIT_GO_B]  = go[1];
    ctrl_word[BIT_FIN_A] = fin[0];
    ctrl_word[BIT_FIN_B] = fin[1];
    ctrl_word[BIT_FAULT] = fault;
    ctrl_word[BIT_IE]    = ie;
    ctrl_word[BIT_SEL]   = sel;
  end

  always_comb begin
    case (int'(reg_addr))
      REG_CTRL:   rd_d = ctrl_word;
      REG_BASE_A: rd_d = DW'(base_w[0]);
      REG_CNT_A:  rd_d = DW'(cnt_w[0]);
      REG_BASE_B: rd_d = DW'(base_w[1]);
      REG_CNT_B:  rd_d = DW'(cnt_w[1]);
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_d;
  end

  // R7
  cnt_width_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == RA_W'(REG_CNT_A)) |=> (reg_rdata[DW-1:CW] == '0));
endmodule

// File: tb/test_pingpong_dma_ch.sv
module test_pingpong_dma_ch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [31:0] exp_q [$];

  always #2 clk = ~clk;

  pingpong_dma_ch i_pingpong_dma_ch (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Memory responder and scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    mem_ack = !rst && mem_req && (cyc % 3 != 1);
    if (mem_req && mem_ack) begin
      if (exp_q.size() == 0) check("R5 unexpected request", mem_addr, 32'hFFFF_FFFF);
      else check("R10 request address", mem_addr, exp_q.pop_front());
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 3'(a);
    @(posedge clk);
    #1 d = reg_rdata;
  endtask

  task automatic wait_ctrl(input logic [31:0] mask, input logic [31:0] val);
    logic [31:0] d;
    for (int i = 0; i < 500; i++) begin
      rd(0, d);
      if ((d & mask) == val) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int i = 0; i < 5; i++) begin
      rd(i, d);
      check("R1 register reset", d, 32'h0);
    end
    check("R1 irq reset", 32'(irq), 32'h0);
    check("R1 mem_req reset", 32'(mem_req), 32'h0);

    // R5/R9/R10: both started together, A first since pointer is 0
    wr(1, 32'h100); wr(2, 3);
    wr(3, 32'h200); wr(4, 2);
    exp_q.push_back(32'h100); exp_q.push_back(32'h101); exp_q.push_back(32'h102);
    exp_q.push_back(32'h200); exp_q.push_back(32'h201);
    wr(0, 32'h003);
    wait_ctrl(32'h20, 32'h20);
    rd(0, d); check("R2 R4 both done, starts clear, pointer back to 0", d, 32'h030);
    rd(1, d); check("R9 address A advanced", d, 32'h103);
    rd(2, d); check("R9 count A exhausted", d, 32'h0);
    rd(3, d); check("R9 address B advanced", d, 32'h202);
    check("R11 irq low while disabled", 32'(irq), 32'h0);

    // R3 clear both done flags
    wr(0, 32'h030);
    rd(0, d); check("R3 done flags cleared", d, 32'h000);

    // R5 pointer on A, only B armed: channel waits
    wr(3, 32'h300); wr(4, 2);
    wr(0, 32'h002);
    repeat (20) @(negedge clk);
    check("R5 no request while pointed buffer unarmed", 32'(mem_req), 32'h0);
    // R6 writes to armed buffer ignored
    wr(3, 32'h999); wr(4, 7);
    rd(3, d); check("R6 armed address protected", d, 32'h300);
    rd(4, d); check("R6 armed count protected", d, 32'h2);
    // R2 writing 0 to start B leaves it set
    rd(0, d); check("R2 start bit held", d, 32'h002);
    wr(1, 32'h400); wr(2, 1);
    exp_q.push_back(32'h400); exp_q.push_back(32'h300); exp_q.push_back(32'h301);
    wr(0, 32'h101);
    wait_ctrl(32'h20, 32'h20);
    rd(0, d); check("R4 R5 A then B done, pointer 0", d, 32'h130);
    check("R11 irq with enable and done", 32'(irq), 32'h1);

    // R3 R11 partial clear keeps irq, full clear drops it
    wr(0, 32'h110);
    rd(0, d); check("R3 done A cleared only", d, 32'h120);
    check("R11 irq still high", 32'(irq), 32'h1);
    wr(0, 32'h120);
    @(negedge clk); @(negedge clk);
    check("R11 irq low after all flags clear", 32'(irq), 32'h0);
    rd(0, d); check("R3 all clear", d, 32'h100);

    // R9 zero count completes with no request
    wr(2, 0);
    wr(0, 32'h101);
    wait_ctrl(32'h10, 32'h10);
    rd(0, d); check("R9 zero count done, R4 pointer to B", d, 32'h310);

    // R7 count masking
    wr(2, 32'hFFFF_FFFF);
    rd(2, d); check("R7 count keeps 13 bits", d, 32'h1FFF);
    wr(0, 32'h110);
    rd(0, d); check("R4 pointer not cleared by write", d, 32'h300);

    // R8 reserved window hit during B
    wr(3, 32'hDFFF_FFFE); wr(4, 4);
    exp_q.push_back(32'hDFFF_FFFE); exp_q.push_back(32'hDFFF_FFFF);
    wr(0, 32'h102);
    wait_ctrl(32'h40, 32'h40);
    rd(0, d); check("R8 fault, start B kept, no done", d, 32'h342);
    rd(4, d); check("R8 count stops at fault", d, 32'h2);
    rd(3, d); check("R8 address stops at window", d, 32'hE000_0000);
    check("R11 irq on fault", 32'(irq), 32'h1);
    wr(0, 32'h140);
    repeat (4) @(negedge clk);
    rd(0, d); check("R8 fault returns after clear, still no done", d, 32'h342);
    check("R10 all expected requests seen", 32'(exp_q.size()), 32'h0);

    summary();
    $finish;
  end
endmodule